// File: doc/BRIEF.md
# Row-Grouping Memory Request Scheduler

This block sits between the request sources of a memory controller and the command generator of a multi-bank SDRAM. It keeps up to `DEPTH` pending accesses. Each access carries a bank, a row, a column, a write flag and a tag. The block decides the order in which they leave. It collects accesses that hit the same row of the same bank into a burst so that one row activation serves several transfers. It moves from bank to bank in round-robin order, so row opening in one bank can overlap data movement in another.

Reads normally go before writes. A write that hits the row of the current burst is placed at the tail of that burst. When too many writes have built up, the preference flips and writes are drained. Two hazards are guarded. Accesses to the same bank, row and column never overtake one another. No burst runs longer than `MAX_BURST`, so other banks are not starved. Each request leaves with its tag unchanged, on a valid/ready issue port. Bank mapping, DRAM timing and data movement are handled elsewhere.

Top module: `rsched_top`

## Requirements
- R1: Once a burst has started, every following issue comes from the same bank and row for as long as an eligible entry with that bank and row is queued and the burst is below its length limit. Within one request class (read or write), entries of a burst leave in arrival order.
- R2: When a new burst starts, its bank is the first bank, in ascending index order and wrapping around, after the bank of the previous burst that holds an eligible entry of the chosen class. Within that bank, the oldest such entry is issued first.
- R3: While fewer than `WR_THRESH` writes are queued, reads are preferred. A new burst opens on a read if any read is eligible, and the reads that match a burst leave before the writes that match it.
- R4: A write is issued only in one of two cases: it matches the bank and row of the running burst and no matching read is eligible, so it is appended to the tail of that burst; or no eligible read exists at all.
- R5: While the number of queued writes is at least `WR_THRESH`, writes are preferred in place of reads, both at burst start and within a burst. This lasts until the count drops below the threshold.
- R6: A burst issues at most `MAX_BURST` accesses. After that, a new burst is chosen by the R2 rule, even if matching entries remain.
- R7: An entry is not issued while an older queued entry has the same bank, row and column. A read therefore never passes an older write to the same address.
- R8: The queue holds `DEPTH` entries. `in_ready` is low exactly when all `DEPTH` entries are occupied, and a request is taken on a cycle where `in_valid` and `in_ready` are both high.
- R9: While `out_valid` is high, `out_ready` is low and no request arrives, the offered request does not change on the next cycle. The request leaves on a cycle where `out_valid` and `out_ready` are both high, and it carries its original tag.
- R10: After reset, `out_valid` is low and `in_ready` is high, and the first burst search begins at bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new request is offered |
| in_ready | output | 1 | Queue can take a request |
| in_bank | input | BANK_W | Target bank of the request |
| in_row | input | ROW_W | Target row |
| in_col | input | COL_W | Target column |
| in_we | input | 1 | 1 = write, 0 = read |
| in_tag | input | TAG_W | Requester tag |
| out_valid | output | 1 | A scheduled request is offered |
| out_ready | input | 1 | Command side accepts the offered request |
| out_bank | output | BANK_W | Bank of the issued request |
| out_row | output | ROW_W | Row of the issued request |
| out_col | output | COL_W | Column of the issued request |
| out_we | output | 1 | Write flag of the issued request |
| out_tag | output | TAG_W | Tag of the issued request |

## Verification
The bench builds the block with `DEPTH` = 8, `MAX_BURST` = 3, `WR_THRESH` = 3 and four banks. With these values a handful of requests is enough to fill the queue, to cut a burst at its limit, and to flip between read preference and write draining. Each scenario is loaded while the issue port is stalled, so the complete ordering decision is made over a known set of entries. The expected tag sequence follows from the grouping, round-robin, preference and hazard rules. The scenarios carry the scheduler state from one to the next, so the round-robin pointer and the open burst at each start are known.

// File: rtl/rsched_pkg.sv
`timescale 1ns/1ps
package rsched_pkg;
   // request class preferred by the selector in the current cycle
   typedef enum logic {
      PREF_RD = 1'b0,
      PREF_WR = 1'b1
   } pref_e;

   // index width that stays at least one bit for single-element sets
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rsched_queue.sv
`timescale 1ns/1ps
module rsched_queue #(
   parameter int DEPTH  = 16,
   parameter int BANK_W = 2,
   parameter int ROW_W  = 8,
   parameter int COL_W  = 6,
   parameter int TAG_W  = 6,
   localparam int IDX_W = rsched_pkg::idx_width(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            push,
   input  logic [BANK_W-1:0]               push_bank,
   input  logic [ROW_W-1:0]                push_row,
   input  logic [COL_W-1:0]                push_col,
   input  logic                            push_we,
   input  logic [TAG_W-1:0]                push_tag,
   input  logic                            pop,
   input  logic [IDX_W-1:0]                pop_idx,
   output logic [DEPTH-1:0]                q_valid,
   output logic [DEPTH-1:0][BANK_W-1:0]    q_bank,
   output logic [DEPTH-1:0][ROW_W-1:0]     q_row,
   output logic [DEPTH-1:0][COL_W-1:0]     q_col,
   output logic [DEPTH-1:0]                q_we,
   output logic [DEPTH-1:0][TAG_W-1:0]     q_tag,
   output logic                            full
);
   // Entries are kept compacted: slot 0 is the oldest, and age grows with index.
   typedef struct packed {
      logic              we;
      logic [BANK_W-1:0] bank;
      logic [ROW_W-1:0]  row;
      logic [COL_W-1:0]  col;
      logic [TAG_W-1:0]  tag;
   } slot_t;

   slot_t            slot_q [DEPTH];
   slot_t            slot_d [DEPTH];
   logic [DEPTH-1:0] val_q, val_d;
   logic [CNT_W-1:0] count, cnt_d, wr_pos;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];
      val_d = val_q;
      if (pop) begin
         for (int i = 0; i < DEPTH - 1; i++) begin
            if (i >= int'(pop_idx)) begin
               slot_d[i] = slot_q[i+1];
               val_d[i]  = val_q[i+1];
            end
         end
         val_d[DEPTH-1] = 1'b0;
      end
      wr_pos = count - CNT_W'(pop);
      if (push) begin
         slot_d[wr_pos[IDX_W-1:0]].we   = push_we;
         slot_d[wr_pos[IDX_W-1:0]].bank = push_bank;
         slot_d[wr_pos[IDX_W-1:0]].row  = push_row;
         slot_d[wr_pos[IDX_W-1:0]].col  = push_col;
         slot_d[wr_pos[IDX_W-1:0]].tag  = push_tag;
         val_d[wr_pos[IDX_W-1:0]]       = 1'b1;
      end
      cnt_d = count + CNT_W'(push) - CNT_W'(pop);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= '0;
         count <= '0;
      end else begin
         val_q <= val_d;
         count <= cnt_d;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
   end

   assign full    = (count == CNT_W'(DEPTH));
   assign q_valid = val_q;

   for (genvar g = 0; g < DEPTH; g++) begin : g_out
      assign q_bank[g] = slot_q[g].bank;
      assign q_row[g]  = slot_q[g].row;
      assign q_col[g]  = slot_q[g].col;
      assign q_we[g]   = slot_q[g].we;
      assign q_tag[g]  = slot_q[g].tag;
   end

   // R8: occupancy never passes the configured depth
   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
endmodule

// File: rtl/rsched_rr.sv
`timescale 1ns/1ps
module rsched_rr #(
   parameter int N = 4,
   localparam int IW = rsched_pkg::idx_width(N)
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] last,
   output logic          any,
   output logic [IW-1:0] grant
);
   assign any = |req;

   if (N == 1) begin : g_single
      logic unused_last;
      assign unused_last = ^last;
      assign grant = '0;
   end else begin : g_rotate
      logic          hit;
      logic [IW-1:0] idx;
      always_comb begin
         grant = '0;
         hit   = 1'b0;
         idx   = '0;
         // search starts just after the previous winner and wraps around
         for (int k = 1; k <= N; k++) begin
            idx = IW'((int'(last) + k) % N);
            if (!hit && req[idx]) begin
               hit   = 1'b1;
               grant = idx;
            end
         end
      end
   end
endmodule

// File: rtl/rsched_pick.sv
`timescale 1ns/1ps
module rsched_pick #(
   parameter int DEPTH     = 16,
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2,
   parameter int ROW_W     = 8,
   parameter int COL_W     = 6,
   parameter int MAX_BURST = 8,
   parameter int WR_THRESH = 6,
   localparam int IDX_W    = rsched_pkg::idx_width(DEPTH),
   localparam int BC_W     = $clog2(MAX_BURST + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [DEPTH-1:0]             q_valid,
   input  logic [DEPTH-1:0][BANK_W-1:0] q_bank,
   input  logic [DEPTH-1:0][ROW_W-1:0]  q_row,
   input  logic [DEPTH-1:0][COL_W-1:0]  q_col,
   input  logic [DEPTH-1:0]             q_we,
   input  logic                         burst_live,
   input  logic [BANK_W-1:0]            cur_bank,
   input  logic [ROW_W-1:0]             cur_row,
   input  logic [BC_W-1:0]              burst_cnt,
   input  logic [BANK_W-1:0]            last_bank,
   output logic                         sel_valid,
   output logic [IDX_W-1:0]             sel_idx,
   output logic                         sel_new
);
   import rsched_pkg::*;

   logic [DEPTH-1:0] blocked, elig, match, pref_mask;
   logic [DEPTH-1:0] m_pref, cont_set, c_pref, new_set, grant_set, final_set;
   logic [NUM_BANKS-1:0][DEPTH-1:0] bank_hit;
   logic [NUM_BANKS-1:0] bank_req;
   logic [BANK_W-1:0]    grant_bank;
   logic                 bank_any, cont, drain;
   pref_e                pref;

   // same-address ordering: any older live entry with equal bank/row/col blocks
   for (genvar i = 0; i < DEPTH; i++) begin : g_haz
      logic [DEPTH-1:0] older_hit;
      for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
         if (j < i) begin : g_old
            assign older_hit[j] = q_valid[j] && (q_bank[j] == q_bank[i]) &&
                                  (q_row[j] == q_row[i]) && (q_col[j] == q_col[i]);
         end else begin : g_young
            assign older_hit[j] = 1'b0;
         end
      end
      assign blocked[i] = |older_hit;
      assign match[i]   = elig[i] && (q_bank[i] == cur_bank) && (q_row[i] == cur_row);
   end

   assign elig      = q_valid & ~blocked;
   assign drain     = $countones(q_valid & q_we) >= WR_THRESH;
   assign pref      = drain ? PREF_WR : PREF_RD;
   assign pref_mask = (pref == PREF_WR) ? q_we : ~q_we;

   // continuing the open burst
   assign m_pref   = match & pref_mask;
   assign cont_set = (|m_pref) ? m_pref : match;
   assign cont     = burst_live && (burst_cnt < BC_W'(MAX_BURST)) && (|match);

   // opening a new burst
   assign c_pref  = elig & pref_mask;
   assign new_set = (|c_pref) ? c_pref : elig;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         assign bank_hit[b][i] = (q_bank[i] == BANK_W'(b));
      end
      assign bank_req[b] = |(new_set & bank_hit[b]);
   end

   rsched_rr #(.N(NUM_BANKS)) u_rr (
      .req   (bank_req),
      .last  (last_bank),
      .any   (bank_any),
      .grant (grant_bank)
   );

   assign grant_set = bank_any ? (new_set & bank_hit[grant_bank]) : '0;
   assign final_set = cont ? cont_set : grant_set;
   assign sel_valid = |final_set;
   assign sel_new   = !cont;

   // oldest entry (lowest slot) of the chosen set
   always_comb begin
      sel_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (final_set[i]) sel_idx = IDX_W'(i);
      end
   end

   // R5: in drain mode a new burst opens on a write whenever one is eligible
   assert_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (drain && |(elig & q_we) && !cont) |-> (sel_valid && q_we[sel_idx]));
endmodule

// File: rtl/rsched_top.sv
`timescale 1ns/1ps
module rsched_top #(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 8,
   parameter int COL_W     = 6,
   parameter int TAG_W     = 6,
   parameter int DEPTH     = 16,
   parameter int MAX_BURST = 8,
   parameter int WR_THRESH = 6,
   localparam int BANK_W   = rsched_pkg::idx_width(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [BANK_W-1:0] in_bank,
   input  logic [ROW_W-1:0]  in_row,
   input  logic [COL_W-1:0]  in_col,
   input  logic              in_we,
   input  logic [TAG_W-1:0]  in_tag,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BANK_W-1:0] out_bank,
   output logic [ROW_W-1:0]  out_row,
   output logic [COL_W-1:0]  out_col,
   output logic              out_we,
   output logic [TAG_W-1:0]  out_tag
);
   localparam int IDX_W = rsched_pkg::idx_width(DEPTH);
   localparam int BC_W  = $clog2(MAX_BURST + 1);

   if (DEPTH < 2) begin : g_chk_depth
      $error("rsched_top: DEPTH must be at least 2");
   end
   if (NUM_BANKS < 1) begin : g_chk_banks
      $error("rsched_top: NUM_BANKS must be at least 1");
   end
   if (MAX_BURST < 1) begin : g_chk_burst
      $error("rsched_top: MAX_BURST must be at least 1");
   end
   if (WR_THRESH < 1 || WR_THRESH > DEPTH) begin : g_chk_thresh
      $error("rsched_top: WR_THRESH must lie in 1..DEPTH");
   end

   logic [DEPTH-1:0]             q_valid, q_we;
   logic [DEPTH-1:0][BANK_W-1:0] q_bank;
   logic [DEPTH-1:0][ROW_W-1:0]  q_row;
   logic [DEPTH-1:0][COL_W-1:0]  q_col;
   logic [DEPTH-1:0][TAG_W-1:0]  q_tag;
   logic                         full, fire, sel_valid, sel_new;
   logic [IDX_W-1:0]             sel_idx;

   logic                         burst_live;
   logic [BANK_W-1:0]            cur_bank, last_bank;
   logic [ROW_W-1:0]             cur_row;
   logic [BC_W-1:0]              burst_cnt;

   assign in_ready  = !full;
   assign out_valid = sel_valid;
   assign fire      = sel_valid && out_ready;
   assign out_bank  = q_bank[sel_idx];
   assign out_row   = q_row[sel_idx];
   assign out_col   = q_col[sel_idx];
   assign out_we    = q_we[sel_idx];
   assign out_tag   = q_tag[sel_idx];

   rsched_queue #(
      .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W)
   ) u_queue (
      .clk(clk), .rst_n(rst_n),
      .push(in_valid && in_ready), .push_bank(in_bank), .push_row(in_row),
      .push_col(in_col), .push_we(in_we), .push_tag(in_tag),
      .pop(fire), .pop_idx(sel_idx),
      .q_valid(q_valid), .q_bank(q_bank), .q_row(q_row), .q_col(q_col),
      .q_we(q_we), .q_tag(q_tag), .full(full)
   );

   rsched_pick #(
      .DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W),
      .COL_W(COL_W), .MAX_BURST(MAX_BURST), .WR_THRESH(WR_THRESH)
   ) u_pick (
      .clk(clk), .rst_n(rst_n),
      .q_valid(q_valid), .q_bank(q_bank), .q_row(q_row), .q_col(q_col), .q_we(q_we),
      .burst_live(burst_live), .cur_bank(cur_bank), .cur_row(cur_row),
      .burst_cnt(burst_cnt), .last_bank(last_bank),
      .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_new(sel_new)
   );

   // burst bookkeeping: open bank/row, length so far, bank of the latest burst
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         burst_live <= 1'b0;
         cur_bank   <= '0;
         cur_row    <= '0;
         burst_cnt  <= '0;
         last_bank  <= BANK_W'(NUM_BANKS - 1);
      end else if (fire) begin
         burst_live <= 1'b1;
         if (sel_new) begin
            cur_bank  <= out_bank;
            cur_row   <= out_row;
            last_bank <= out_bank;
            burst_cnt <= BC_W'(1);
         end else begin
            burst_cnt <= burst_cnt + BC_W'(1);
         end
      end
   end

   // R6: a burst never grows past its limit
   assert_burst_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      burst_cnt <= BC_W'(MAX_BURST));

   // R1: an issue that continues the burst stays on its bank and row
   assert_cont_row_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !sel_new) |-> (out_bank == cur_bank && out_row == cur_row));

   // R9: a stalled offer with no arrivals is held unchanged
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !in_valid) |=> (out_valid && $stable(out_tag)));
endmodule

// File: tb/rsched_top_tb.sv
`timescale 1ns/1ps
module rsched_top_tb;
   localparam int NB = 4, RW = 4, CW = 4, TW = 8, DEP = 8, MB = 3, WT = 3;
   localparam int BW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0, in_we = 1'b0, out_ready = 1'b0;
   logic [BW-1:0] in_bank = '0;
   logic [RW-1:0] in_row = '0;
   logic [CW-1:0] in_col = '0;
   logic [TW-1:0] in_tag = '0;
   logic          in_ready, out_valid, out_we;
   logic [BW-1:0] out_bank;
   logic [RW-1:0] out_row;
   logic [CW-1:0] out_col;
   logic [TW-1:0] out_tag;

   int    n_checks = 0;
   int    n_errors = 0;
   int    exp_tag[$];
   string exp_req[$];

   always #2.5 clk = ~clk;

   rsched_top #(
      .NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .TAG_W(TW),
      .DEPTH(DEP), .MAX_BURST(MB), .WR_THRESH(WT)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_bank(in_bank), .in_row(in_row),
      .in_col(in_col), .in_we(in_we), .in_tag(in_tag),
      .out_valid(out_valid), .out_ready(out_ready), .out_bank(out_bank),
      .out_row(out_row), .out_col(out_col), .out_we(out_we), .out_tag(out_tag)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push_req(input int b, input int r, input int c, input int w, input int t);
      while (!in_ready) begin @(posedge clk); #1; end
      in_valid = 1'b1;
      in_bank  = BW'(b);
      in_row   = RW'(r);
      in_col   = CW'(c);
      in_we    = w[0];
      in_tag   = TW'(t);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic expect_tag(input int t, input string req);
      exp_tag.push_back(t);
      exp_req.push_back(req);
   endtask

   task automatic drain_out();
      out_ready = 1'b1;
      for (int k = 0; k < 200 && exp_tag.size() != 0; k++) begin
         @(posedge clk); #1;
      end
      out_ready = 1'b0;
      check(exp_tag.size() == 0, "R9 drain", exp_tag.size(), 0);
      exp_tag.delete();
      exp_req.delete();
   endtask

   // scoreboard monitor: compares each handshake against the expected order
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (exp_tag.size() == 0) begin
            check(1'b0, "R9 unexpected issue", int'(out_tag), -1);
         end else begin
            automatic int    t = exp_tag.pop_front();
            automatic string r = exp_req.pop_front();
            check(int'(out_tag) == t, r, int'(out_tag), t);
         end
      end
   end

   initial begin
      #1000000;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      check(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
      check(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);

      // S1: grouping and round-robin, search starts at bank 0
      push_req(1, 5, 0, 0, 1);
      push_req(0, 1, 0, 0, 2);
      push_req(0, 2, 0, 0, 3);
      push_req(1, 5, 1, 0, 4);
      push_req(0, 1, 1, 0, 5);
      check(out_valid && out_tag == 8'd2, "R10 first offer from bank 0", out_tag, 2);
      @(posedge clk); #1;
      check(out_valid && out_tag == 8'd2, "R9 offer held while stalled", out_tag, 2);
      expect_tag(2, "R2");
      expect_tag(5, "R1");
      expect_tag(1, "R2");
      expect_tag(4, "R1");
      expect_tag(3, "R2");
      drain_out();

      // S2: reads ahead of writes, matching write at the burst tail
      push_req(2, 3, 0, 1, 10);
      push_req(2, 3, 1, 0, 11);
      push_req(1, 6, 0, 0, 12);
      push_req(2, 4, 0, 1, 13);
      expect_tag(12, "R3");
      expect_tag(11, "R3");
      expect_tag(10, "R4");
      expect_tag(13, "R4");
      drain_out();

      // S3: write count at threshold flips preference to writes
      push_req(3, 1, 0, 0, 20);
      push_req(0, 7, 0, 1, 21);
      push_req(0, 7, 1, 1, 22);
      push_req(1, 2, 0, 1, 23);
      expect_tag(21, "R5");
      expect_tag(22, "R4");
      expect_tag(20, "R3");
      expect_tag(23, "R2");
      drain_out();

      // S4: burst cut at MAX_BURST
      push_req(2, 9, 0, 0, 30);
      push_req(2, 9, 1, 0, 31);
      push_req(2, 9, 2, 0, 32);
      push_req(2, 9, 3, 0, 33);
      push_req(3, 0, 0, 0, 34);
      expect_tag(30, "R1");
      expect_tag(31, "R1");
      expect_tag(32, "R1");
      expect_tag(34, "R6");
      expect_tag(33, "R6");
      drain_out();

      // S5: read may not pass an older write to the same address
      push_req(3, 4, 5, 1, 40);
      push_req(3, 4, 5, 0, 41);
      push_req(3, 4, 6, 0, 42);
      expect_tag(42, "R7");
      expect_tag(40, "R7");
      expect_tag(41, "R7");
      drain_out();

      // S6: fill to depth, then arrival order under repeated burst cuts
      for (int c = 0; c < DEP; c++) push_req(0, 1, c, 0, 50 + c);
      check(in_ready == 1'b0, "R8 in_ready low when full", in_ready, 0);
      for (int c = 0; c < DEP; c++) expect_tag(50 + c, "R1");
      drain_out();
      check(in_ready == 1'b1, "R8 in_ready back after drain", in_ready, 1);
      check(out_valid == 1'b0, "R8 queue empty after drain", out_valid, 0);

      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule